// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block turns a local-bus address into a PCI bus address using three programmable windows. Each window is a pair of registers: a base register that says which local addresses the window claims, and a map register that says where those addresses land on PCI. Windows 0 and 1 are general memory windows. Each has a size from 1 MB to 2 GB, a PCI cycle type and a prefetch attribute. Window 2 is a fixed 16 MB window that always issues I/O cycles.

Windows may overlap. The block tests them in index order, and the lowest enabled window that claims the address wins. Software uses this to borrow a window. It enlarges window 0 until window 0 covers window 1's range. Window 1 is then hidden and can be pointed at configuration space, and it is restored afterwards.

The block samples a request on each clock. The translated address, cycle type, prefetch flag, window index and hit flag are registered and appear one cycle after the request is sampled.

Top module: `bus_win_xlat`

## Requirements
- R1: After reset every register reads zero. No request hits until a window is enabled.
- R2: Configuration slots are numbered 0 to 5. Their order is: memory base 0, memory map 0, memory base 1, memory map 1, I/O base, I/O map.
  - The memory base slots keep all 32 bits.
  - The map slots and the I/O base slot keep only bits 15:0 and read back zero-extended.
  - Slots 6 and 7 read zero and ignore writes.
  - Swap fields (memory base bits 9:8 and I/O base bits 7:6) are stored and read back. They have no effect on translation.
- R3: A memory window (0 or 1) claims an address only when its enable bit (base bit 0) is set. Its size is 1 MB shifted left by the size code in base bits 7:4. The window claims an address when the address bits above the window size equal base bits 31:20 at the same positions.
- R4: A memory window whose size code is above 11 never claims any address.
- R5: For a memory window, the PCI address takes bits above the window size from map bits 15:4, which hold PCI bits 31:20. Bits below the window size pass through from the local address.
- R6: A memory window's cycle type comes from map bits 3:1 and its prefetch flag from base bit 3. The cycle type codes are: 0 interrupt acknowledge, 1 I/O, 3 memory, 5 configuration, 6 memory read-multiple.
- R7: The I/O window is enabled by its base bit 0. It claims an address when the local address bits 31:24 equal its base bits 15:8. Its PCI address is map bits 15:8 followed by local bits 23:0. It reports cycle type 1 and prefetch 0.
- R8: When several enabled windows claim an address, the lowest-numbered one is used. The window index output reports which one.
- R9: With a configuration cycle type (5) and map bit 0 clear, PCI address bits 1:0 are forced to 00. With map bit 0 set, they pass through.
- R10: When no window claims the address, or no request is valid, the hit output is low and every other result output is zero.
- R11: Results appear one clock after the request is sampled. Register writes take effect for requests sampled after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register slot index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected slot |
| req_valid | input | 1 | Local-bus request valid |
| req_addr | input | 32 | Local-bus request address |
| xl_hit | output | 1 | A window claimed the request |
| xl_addr | output | 32 | Translated PCI address |
| xl_cyc | output | 3 | PCI cycle type code |
| xl_pref | output | 1 | Prefetchable attribute |
| xl_win | output | 2 | Index of the claiming window |

## Verification
The hardest case to reach is the one this block exists for: an address claimed by two enabled windows at once, with the lower one carrying a different map and cycle type. The bench first programs non-overlapping windows. It then widens window 0 from 256 MB to 512 MB, so that window 0 swallows window 1's range, and checks that the same address now reports window 0's translation. Next it moves window 1 onto a configuration range and checks that range with the low-address enable both clear and set.

// File: rtl/bus_win_xlat_pkg.sv
package bus_win_xlat_pkg;
  localparam int AW        = 32;
  localparam int NUM_WIN   = 3;
  localparam int WIN_IDX_W = $clog2(NUM_WIN);
  localparam int MIN_SHIFT = 20;   // smallest memory window: 1 MB
  localparam int MAX_CODE  = 11;   // largest legal size code
  localparam int IO_SHIFT  = 24;   // fixed I/O window: 16 MB
  localparam int NUM_REGS  = 2 * NUM_WIN;
  localparam int SEL_W     = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    CYC_IACK   = 3'd0,
    CYC_IO     = 3'd1,
    CYC_MEM    = 3'd3,
    CYC_CFG    = 3'd5,
    CYC_MEMMUL = 3'd6
  } cyc_e;

  typedef struct packed {
    logic          hit;
    logic [AW-1:0] addr;
    logic [2:0]    cyc;
    logic          pref;
  } win_res_t;

  typedef struct packed {
    logic                 hit;
    logic [AW-1:0]        addr;
    logic [2:0]           cyc;
    logic                 pref;
    logic [WIN_IDX_W-1:0] win;
  } xl_out_t;
endpackage

// File: rtl/win_regs.sv
module win_regs
  import bus_win_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [AW-1:0]     wdata,
  output logic [AW-1:0]     rdata,
  output logic [AW-1:0]     regs [NUM_REGS]
);
  // Slot 0 and 2 keep 32 bits; all other slots keep 16 bits.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [AW-1:0] KEEP = (g == 0 || g == 2) ? {AW{1'b1}} : {{(AW-16){1'b0}}, 16'hFFFF};
    logic          en_w;
    logic [AW-1:0] d_w;

    always_comb begin
      en_w = we && (sel == SEL_W'(g));
      d_w  = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs[g] <= '0;
      else if (en_w) regs[g] <= d_w;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (sel == SEL_W'(i)) rdata = regs[i];
  end

  a_r2_narrow_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[1][AW-1:16] == '0) && (regs[3][AW-1:16] == '0) &&
    (regs[4][AW-1:16] == '0) && (regs[5][AW-1:16] == '0));
endmodule

// File: rtl/win_match.sv
module win_match
  import bus_win_xlat_pkg::*;
#(
  parameter bit IO_WIN = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] map,
  input  logic [AW-1:0] addr,
  output win_res_t      res
);
  if (IO_WIN) begin : g_io
    logic unused_io;
    always_comb begin
      unused_io = ^{base[AW-1:16], base[7:1], map[AW-1:16], map[7:0]};
      res       = '0;
      if (base[0] && (addr[AW-1:IO_SHIFT] == base[15:8])) begin
        res.hit  = 1'b1;
        res.addr = {map[15:8], addr[IO_SHIFT-1:0]};
        res.cyc  = CYC_IO;
        res.pref = 1'b0;
      end
    end

    a_r7_io_type: assert property (@(posedge clk) disable iff (!rst_n)
      res.hit |-> (res.cyc == CYC_IO) && !res.pref);
  end else begin : g_mem
    logic [3:0]    code;
    logic [4:0]    shift;
    logic [AW-1:0] lo_mask;
    logic [AW-1:0] map_hi;
    logic          legal;
    logic          unused_mem;

    always_comb begin
      unused_mem = ^{base[19:10], base[9:8], base[2:1], map[AW-1:16]};
      code    = base[7:4];
      legal   = (code <= 4'(MAX_CODE));
      shift   = 5'(MIN_SHIFT) + {1'b0, code};
      lo_mask = (AW'(1) << shift) - AW'(1);
      map_hi  = {map[15:4], {MIN_SHIFT{1'b0}}};
      res     = '0;
      if (base[0] && legal && (((addr ^ base) & ~lo_mask) == '0)) begin
        res.hit  = 1'b1;
        res.addr = (map_hi & ~lo_mask) | (addr & lo_mask);
        res.cyc  = map[3:1];
        res.pref = base[3];
        if ((map[3:1] == CYC_CFG) && !map[0]) res.addr[1:0] = 2'b00;
      end
    end

    a_r4_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (base[7:4] > 4'(MAX_CODE)) |-> !res.hit);
    a_r9_cfg_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res.hit && (res.cyc == CYC_CFG) && !map[0]) |-> (res.addr[1:0] == 2'b00));
  end
endmodule

// File: rtl/win_select.sv
module win_select
  import bus_win_xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  win_res_t cand [NUM_WIN],
  output xl_out_t  pick
);
  logic [NUM_WIN-1:0] grant;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    pick  = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (req_valid && cand[i].hit && !found) begin
        found     = 1'b1;
        grant[i]  = 1'b1;
        pick.hit  = 1'b1;
        pick.addr = cand[i].addr;
        pick.cyc  = cand[i].cyc;
        pick.pref = cand[i].pref;
        pick.win  = WIN_IDX_W'(i);
      end
    end
  end

  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r8_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cand[0].hit) |-> (pick.win == '0));
endmodule

// File: rtl/bus_win_xlat.sv
module bus_win_xlat
  import bus_win_xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        xl_hit,
  output logic [31:0] xl_addr,
  output logic [2:0]  xl_cyc,
  output logic        xl_pref,
  output logic [1:0]  xl_win
);
  logic [AW-1:0] regs [NUM_REGS];
  win_res_t      cand [NUM_WIN];
  xl_out_t       nxt, cur;

  win_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs(regs)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_match #(.IO_WIN(w == NUM_WIN - 1)) u_match (
      .clk(clk), .rst_n(rst_n),
      .base(regs[2*w]), .map(regs[2*w+1]),
      .addr(req_addr), .res(cand[w])
    );
  end

  win_select u_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cand(cand), .pick(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  always_comb begin
    xl_hit  = cur.hit;
    xl_addr = cur.addr;
    xl_cyc  = cur.cyc;
    xl_pref = cur.pref;
    xl_win  = cur.win;
  end

  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_hit |-> (xl_addr == '0) && (xl_cyc == '0) && !xl_pref && (xl_win == '0));
  a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !xl_hit);
  a_r7_io_win_type: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit && (xl_win == 2'd2)) |-> (xl_cyc == 3'd1) && !xl_pref);
endmodule

// File: tb/bus_win_xlat_tb.sv
module bus_win_xlat_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        xl_hit;
  logic [31:0] xl_addr;
  logic [2:0]  xl_cyc;
  logic        xl_pref;
  logic [1:0]  xl_win;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_win_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .xl_hit(xl_hit), .xl_addr(xl_addr),
    .xl_cyc(xl_cyc), .xl_pref(xl_pref), .xl_win(xl_win)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, int sel, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = 3'(sel);
    #1;
    chk(req, 64'(cfg_rdata), 64'(exp));
  endtask

  // Drive a request, let one edge register it, sample at the next falling edge.
  task automatic xl_chk(string req, logic v, logic [31:0] a, logic eh,
                        logic [31:0] ea, logic [2:0] ec, logic ep, logic [1:0] ew);
    @(negedge clk);
    req_valid = v; req_addr = a;
    @(negedge clk);
    chk(req, {xl_hit, xl_addr, xl_cyc, xl_pref, xl_win},
             {eh, ea, ec, ep, ew});
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R1 reset read", i, 32'h0);
    xl_chk("R1 reset miss", 1, 32'h4000_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_regs;
    wr(1, 32'hFFFF_1234);
    rd_chk("R2 narrow map", 1, 32'h0000_1234);
    wr(7, 32'hDEAD_BEEF);
    rd_chk("R2 unused slot", 7, 32'h0);
    wr(0, 32'h4000_0380);   // swap bits set, disabled
    rd_chk("R2 swap kept", 0, 32'h4000_0380);
    xl_chk("R3 disabled window", 1, 32'h4123_4567, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mem;
    wr(0, 32'h4000_0381);   // 256 MB, swap bits set
    wr(1, 32'h0000_0006);   // memory cycle, PCI 0
    xl_chk("R5 win0 xlate", 1, 32'h4123_4567, 1, 32'h0123_4567, 3'd3, 0, 2'd0);
    xl_chk("R3 win0 edge miss", 1, 32'h5000_0000, 0, 0, 0, 0, 0);
    xl_chk("R10 invalid req", 0, 32'h4123_4567, 0, 0, 0, 0, 0);
    wr(2, 32'h5000_0089);   // 256 MB prefetch
    wr(3, 32'h0000_100C);   // read-multiple at PCI 0x10000000
    xl_chk("R6 win1 pref", 1, 32'h5ABC_DEF0, 1, 32'h1ABC_DEF0, 3'd6, 1, 2'd1);
  endtask

  task automatic t_io;
    wr(4, 32'h0000_6001);
    wr(5, 32'h0000_0000);
    xl_chk("R7 io xlate", 1, 32'h6012_3456, 1, 32'h0012_3456, 3'd1, 0, 2'd2);
    wr(5, 32'h0000_AB00);
    xl_chk("R7 io map", 1, 32'h6012_3456, 1, 32'hAB12_3456, 3'd1, 0, 2'd2);
    xl_chk("R10 io miss", 1, 32'h6100_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_overlap;
    wr(0, 32'h4000_0091);   // 512 MB: hides window 1
    xl_chk("R8 lower wins", 1, 32'h5ABC_DEF0, 1, 32'h1ABC_DEF0, 3'd3, 0, 2'd0);
    wr(2, 32'h6100_0041);   // 16 MB config window
    wr(3, 32'h0000_000A);   // config, low enable clear
    xl_chk("R9 cfg low forced", 1, 32'h6100_0803, 1, 32'h0000_0800, 3'd5, 0, 2'd1);
    wr(3, 32'h0000_000B);
    xl_chk("R9 cfg low pass", 1, 32'h6100_0803, 1, 32'h0000_0803, 3'd5, 0, 2'd1);
    wr(2, 32'h0000_0000);
  endtask

  task automatic t_sizes;
    wr(0, 32'h4000_00C1);   // code 12
    xl_chk("R4 bad code", 1, 32'h4123_4567, 0, 0, 0, 0, 0);
    wr(0, 32'h4000_00B1);   // code 11: 2 GB
    xl_chk("R3 2GB hit", 1, 32'h4123_4567, 1, 32'h4123_4567, 3'd3, 0, 2'd0);
    xl_chk("R3 2GB miss", 1, 32'h8000_0000, 0, 0, 0, 0, 0);
    wr(0, 32'h4000_0001);   // code 0: 1 MB
    wr(1, 32'h0000_7FF6);
    xl_chk("R5 1MB top", 1, 32'h400F_FFFF, 1, 32'h7FFF_FFFF, 3'd3, 0, 2'd0);
    xl_chk("R3 1MB miss", 1, 32'h4010_0000, 0, 0, 0, 0, 0);
  endtask

  task automatic t_timing;
    // R11: write and request in the same low phase; request sampled on the write edge sees old map.
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 32'h0000_0016;
    req_valid = 1'b1; req_addr = 32'h4000_0010;
    @(negedge clk);
    chk("R11 old map", {xl_hit, xl_addr}, {1'b1, 32'h7FF0_0010});
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R11 new map", {xl_hit, xl_addr}, {1'b1, 32'h0010_0010});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 idle next", 64'(xl_hit), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_mem;
    t_io;
    t_overlap;
    t_sizes;
    t_timing;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule